// File: doc/BRIEF.md
# Segmented DAC Code Decoder

This block turns a 16-bit sample into the switch controls of a segmented current-steering converter. The top four bits of the sample are expanded into a 15-line thermometer pattern. Each line switches one of fifteen unit current sources of equal weight. The low twelve bits go straight through as the controls of a binary-weighted ladder. A mode field travels with each sample and says how the sample is coded. In straight binary, zero means zero output and all ones means one LSB below full scale. In offset binary, zero means minus full scale and 8000h means the midpoint. In two's complement, the top bit is inverted before decoding, so the sample is handled as offset binary from then on.

Samples arrive on a valid/ready stream, and the decoded pattern leaves on another. A single output register holds the thermometer lines, the ladder bits, a span flag and a reconstructed weight. All of them load on the same clock edge, so a segment change never pairs with stale ladder bits. The span flag tells the analog stage to take the bipolar span. The weight is the sum that the switches represent, so a bench can confirm that the reconstruction is monotonic.

Back-pressure works as follows. The input accepts a sample whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value and `in_ready` stays low.

Top module: `dac_seg_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, the following edge leaves `out_valid`, `out_therm`, `out_ladder`, `out_weight` and `out_span_bipolar` all at zero.
- R2: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A sample accepted at an edge (`in_valid` and `in_ready` both high) appears on the outputs after that edge with `out_valid` high. With no sample accepted and `out_ready` high, `out_valid` is low after the edge.
- R3: While `out_valid` is high and `out_ready` is low, all outputs keep their values at the next edge, and a sample offered on the input is not taken.
- R4: Thermometer line k, carried on `out_therm[k-1]` for k from 1 to 15, is high exactly when the 4-bit segment value is k or more. A segment of zero drives no line.
- R5: `out_ladder` equals bits 11:0 of the accepted sample in every mode.
- R6: When `in_mode` is 2'b10 or 2'b11 (two's complement), the segment value is {~bit15, bit14..bit12} of the sample.
- R7: When `in_mode` is 2'b00 (straight binary) or 2'b01 (offset binary), the segment value is bits 15:12 unchanged. `out_span_bipolar` is low for 2'b00 and high for every other mode.
- R8: `out_weight` (17 bits) equals the number of high thermometer lines times 4096 plus `out_ladder`. In the straight and offset modes this equals the sample value. In two's-complement mode it equals the sample with bit 15 inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers load on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is offered |
| in_ready | output | 1 | The block can take the offered sample |
| in_code | input | 16 | Sample to decode |
| in_mode | input | 2 | Coding of the sample: 00 straight, 01 offset, 10/11 two's complement |
| out_valid | output | 1 | The outputs hold a decoded sample |
| out_ready | input | 1 | The consumer takes the decoded sample |
| out_therm | output | 15 | Unit-source switch lines, thermometer coded |
| out_ladder | output | 12 | Binary-weighted ladder switch bits |
| out_weight | output | 17 | Reconstructed code weight of the switch pattern |
| out_span_bipolar | output | 1 | Selects the bipolar span in the analog stage |

## Verification
Every decoded result is due one clock after the sample is accepted, because exactly one register lies between `in_code` and the outputs. The bench drives each sample on a falling edge and lets the next rising edge accept it. It then compares all four outputs on the following falling edge, which is half a period after the register loads. In the stall sequence the bench holds `out_ready` low for several cycles and checks for unchanged outputs on each falling edge. It then raises `out_ready` and expects the waiting sample one edge later.

// File: rtl/dac_seg_pkg.sv
package dac_seg_pkg;
  typedef enum logic [1:0] {
    CODE_STRAIGHT = 2'b00,
    CODE_OFFSET   = 2'b01,
    CODE_TWOS     = 2'b10,
    CODE_TWOS_ALT = 2'b11
  } code_mode_e;

  function automatic logic mode_inverts_top(input code_mode_e m);
    return (m == CODE_TWOS) || (m == CODE_TWOS_ALT);
  endfunction

  function automatic logic mode_is_bipolar(input code_mode_e m);
    return m != CODE_STRAIGHT;
  endfunction
endpackage

// File: rtl/dac_seg_premap.sv
module dac_seg_premap
  import dac_seg_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int SEG_W  = 4,
  localparam int LADDER_W = CODE_W - SEG_W
) (
  input  logic [CODE_W-1:0]   code,
  input  code_mode_e          mode,
  output logic [SEG_W-1:0]    seg,
  output logic [LADDER_W-1:0] ladder,
  output logic                span_bipolar
);
  logic flip_top;

  always_comb begin
    flip_top     = mode_inverts_top(mode);
    seg          = code[CODE_W-1:LADDER_W];
    seg[SEG_W-1] = code[CODE_W-1] ^ flip_top;
    ladder       = code[LADDER_W-1:0];
    span_bipolar = mode_is_bipolar(mode);
  end
endmodule

// File: rtl/dac_seg_therm.sv
module dac_seg_therm #(
  parameter int SEG_W = 4,
  localparam int THERM_N = (1 << SEG_W) - 1
) (
  input  logic [SEG_W-1:0]   seg,
  output logic [THERM_N-1:0] therm
);
  for (genvar k = 1; k <= THERM_N; k++) begin : g_line
    assign therm[k-1] = (seg >= SEG_W'(k));
  end
endmodule

// File: rtl/dac_seg_weight.sv
module dac_seg_weight #(
  parameter int SEG_W    = 4,
  parameter int LADDER_W = 12,
  localparam int THERM_N  = (1 << SEG_W) - 1,
  localparam int WEIGHT_W = SEG_W + LADDER_W + 1
) (
  input  logic [THERM_N-1:0]  therm,
  input  logic [LADDER_W-1:0] ladder,
  output logic [WEIGHT_W-1:0] weight
);
  logic [SEG_W-1:0] units;

  always_comb begin
    units = '0;
    for (int i = 0; i < THERM_N; i++) begin
      units = units + SEG_W'(therm[i]);
    end
    weight = WEIGHT_W'({units, ladder});
  end
endmodule

// File: rtl/dac_seg_decoder.sv
module dac_seg_decoder
  import dac_seg_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int SEG_W  = 4,
  localparam int LADDER_W = CODE_W - SEG_W,
  localparam int THERM_N  = (1 << SEG_W) - 1,
  localparam int WEIGHT_W = CODE_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [CODE_W-1:0]   in_code,
  input  logic [1:0]          in_mode,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [THERM_N-1:0]  out_therm,
  output logic [LADDER_W-1:0] out_ladder,
  output logic [WEIGHT_W-1:0] out_weight,
  output logic                out_span_bipolar
);
  logic [SEG_W-1:0]    seg_c;
  logic [LADDER_W-1:0] ladder_c;
  logic                span_c;
  logic [THERM_N-1:0]  therm_c;
  logic [WEIGHT_W-1:0] weight_c;
  logic                take;

  dac_seg_premap #(.CODE_W(CODE_W), .SEG_W(SEG_W)) u_premap (
    .code        (in_code),
    .mode        (code_mode_e'(in_mode)),
    .seg         (seg_c),
    .ladder      (ladder_c),
    .span_bipolar(span_c)
  );

  dac_seg_therm #(.SEG_W(SEG_W)) u_therm (
    .seg  (seg_c),
    .therm(therm_c)
  );

  dac_seg_weight #(.SEG_W(SEG_W), .LADDER_W(LADDER_W)) u_weight (
    .therm (therm_c),
    .ladder(ladder_c),
    .weight(weight_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid        <= 1'b0;
      out_therm        <= '0;
      out_ladder       <= '0;
      out_weight       <= '0;
      out_span_bipolar <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_therm        <= therm_c;
        out_ladder       <= ladder_c;
        out_weight       <= weight_c;
        out_span_bipolar <= span_c;
      end
    end
  end
endmodule

// File: rtl/dac_seg_decoder_chk.sv
module dac_seg_decoder_chk #(
  parameter int CODE_W = 16,
  parameter int SEG_W  = 4,
  localparam int LADDER_W = CODE_W - SEG_W,
  localparam int THERM_N  = (1 << SEG_W) - 1,
  localparam int WEIGHT_W = CODE_W + 1
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic [CODE_W-1:0]   in_code,
  input logic                out_valid,
  input logic                out_ready,
  input logic [THERM_N-1:0]  out_therm,
  input logic [LADDER_W-1:0] out_ladder,
  input logic [WEIGHT_W-1:0] out_weight
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_therm == '0 && out_ladder == '0 && out_weight == '0));

  // R2
  accept_shows_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_therm) &&
                                   $stable(out_ladder) && $stable(out_weight)));

  // R4
  therm_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (out_therm & (out_therm + THERM_N'(1))) == '0);

  // R5
  ladder_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_ladder == $past(in_code[LADDER_W-1:0])));

  // R8
  weight_sum_chk: assert property (@(posedge clk) disable iff (rst)
    out_weight == ((WEIGHT_W'($countones(out_therm)) << LADDER_W) | WEIGHT_W'(out_ladder)));
endmodule

bind dac_seg_decoder dac_seg_decoder_chk #(.CODE_W(CODE_W), .SEG_W(SEG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_code   (in_code),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_therm (out_therm),
  .out_ladder(out_ladder),
  .out_weight(out_weight)
);

// File: tb/dac_seg_decoder_tb.sv
module dac_seg_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_code = '0;
  logic [1:0]  in_mode = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [14:0] out_therm;
  logic [11:0] out_ladder;
  logic [16:0] out_weight;
  logic        out_span_bipolar;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dac_seg_decoder u_dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_therm(out_therm), .out_ladder(out_ladder),
    .out_weight(out_weight), .out_span_bipolar(out_span_bipolar)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] seg_of(input logic [15:0] c, input logic [1:0] m);
    return m[1] ? {~c[15], c[14:12]} : c[15:12];
  endfunction

  task automatic expect_out(input logic [15:0] c, input logic [1:0] m);
    logic [3:0] s;
    s = seg_of(c, m);
    chk("R2 out_valid", 32'(out_valid), 32'd1);
    chk(m[1] ? "R6 therm (twos)" : "R4 therm", 32'(out_therm), 32'((16'd1 << s) - 16'd1));
    chk("R5 ladder", 32'(out_ladder), 32'(c[11:0]));
    chk("R8 weight", 32'(out_weight), m[1] ? 32'(c ^ 16'h8000) : 32'(c));
    chk("R7 span", 32'(out_span_bipolar), 32'(m != 2'b00));
  endtask

  task automatic send_check(input logic [15:0] c, input logic [1:0] m);
    @(negedge clk);
    in_code = c; in_mode = m; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_out(c, m);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset clears everything even with a sample offered
    in_valid = 1'b1; in_code = 16'hFFFF; in_mode = 2'b01;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 therm", 32'(out_therm), 32'd0);
    chk("R1 ladder", 32'(out_ladder), 32'd0);
    chk("R1 weight", 32'(out_weight), 32'd0);
    chk("R1 span", 32'(out_span_bipolar), 32'd0);
    in_valid = 1'b0;
    rst = 1'b0;

    // R4 R5 R7 R8: every code, straight binary
    for (int c = 0; c < 65536; c++) send_check(16'(c), 2'b00);
    // R7: offset binary, no inversion
    for (int s = 0; s < 16; s++)
      for (int l = 0; l < 64; l++)
        send_check({4'(s), 12'((l * 65) & 12'hFFF)}, 2'b01);
    // R6: two's complement with both encodings
    for (int s = 0; s < 16; s++)
      for (int l = 0; l < 64; l++)
        send_check({4'(s), 12'((l * 65 + 7) & 12'hFFF)}, (l[0]) ? 2'b11 : 2'b10);
    send_check(16'h8000, 2'b10);
    chk("R6 zero midpoint therm", 32'(out_therm), 32'd0);
    send_check(16'h7FFF, 2'b10);
    chk("R6 top therm", 32'(out_therm), 32'h7FFF);

    // R2: idle cycle drains out_valid
    @(negedge clk);
    chk("R2 drain", 32'(out_valid), 32'd0);
    chk("R2 in_ready idle", 32'(in_ready), 32'd1);

    // R3: stall holds outputs and refuses a new sample
    in_code = 16'h5A5A; in_mode = 2'b00; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    expect_out(16'h5A5A, 2'b00);
    in_code = 16'hC3C3; in_mode = 2'b10;
    for (int i = 0; i < 3; i++) begin
      chk("R3 in_ready low", 32'(in_ready), 32'd0);
      @(negedge clk);
      chk("R3 hold therm", 32'(out_therm), 32'h001F);
      chk("R3 hold weight", 32'(out_weight), 32'h5A5A);
      chk("R3 hold valid", 32'(out_valid), 32'd1);
    end
    out_ready = 1'b1;
    #1;
    chk("R2 in_ready on drain", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    expect_out(16'hC3C3, 2'b10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule